// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four reset requests into a single system reset and keeps a record of which requests caused it. The requests are a power-on detect level, an active-low external reset pin, a watchdog expiry pulse, and a brown-out detect level that only counts while its enable is set. The pin and the brown-out level must stay active for a minimum number of clock cycles before they count. Each of them first passes a two-flop synchroniser and then a run-length filter.

Any request that has been recognised sets the system reset at once, through the asynchronous set of the output flops. No clock edge is needed for this. Once every request is inactive, a delay counter runs for one of four cycle counts, picked by a 2-bit select input. After that, the release passes a two-flop synchroniser, so the system reset falls on a clock edge. A four-bit cause register is always visible at the outputs. Software clears a bit by writing zero to it.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high. When `por_i` rises, `sys_rst_o` rises in the same half cycle, before any clock edge.
- R2: A watchdog pulse (`wdt_expire_i` high) drives `sys_rst_o` high at once, without waiting for a clock edge.
- R3: With no request active, `sys_rst_o` falls just after the (L+3)-th consecutive rising edge at which no request was active. L is 4, 8, 16 or 32 for `dly_sel_i` = 0, 1, 2 or 3 (parameters `DLY0`..`DLY3`).
- R4: The pin request is recognised only after `ext_rst_n_i` has been sampled low on `MIN_PIN` consecutive edges (default 4). The recognition follows after a two-edge synchroniser. A shorter low pulse neither resets nor sets a flag.
- R5: The brown-out request is recognised only after `bod_det_i & bod_en_i` has been sampled high on `MIN_BOD` consecutive edges (default 6). A shorter pulse is ignored.
- R6: While `bod_en_i` is low, `bod_det_i` has no effect on `sys_rst_o` or `flags_o`.
- R7: `flags_o` bit 0 is power-on, bit 1 is pin, bit 2 is brown-out and bit 3 is watchdog. Power-on forces `flags_o` to 4'b0001 asynchronously, and it stays there while `por_i` is high.
- R8: A recognised pin or brown-out request, or a watchdog pulse, sets only its own flag. Flags accumulate.
- R9: When `flag_wr_i` is high on an edge, every flag whose bit in `flag_wdata_i` is 0 is cleared. Bits written 1 are unchanged. A source that sets a flag on the same edge wins over the clear.
- R10: A new request during the release delay restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on detect, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| bod_det_i | input | 1 | Brown-out detect level |
| bod_en_i | input | 1 | Brown-out reset enable |
| dly_sel_i | input | 2 | Release delay select |
| flag_wr_i | input | 1 | Cause register write strobe |
| flag_wdata_i | input | 4 | Write data; 0 bits clear flags |
| flags_o | output | 4 | Reset cause flags |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The hardest situation to reach is a second request that arrives while the release delay is already counting. Any check that only measures release time from a single event misses it. The bench therefore fires a watchdog pulse partway through a stretch and measures the release from the later pulse. A second hard case is a write that clears a flag on the very edge where the watchdog sets it. The bench lines up the strobe and the pulse on one edge to reach it. The per-cycle reference model also walks the filters through pulses exactly one cycle shorter than their threshold.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int FLAG_W   = 4;
  localparam int FLAG_POR = 0;
  localparam int FLAG_PIN = 1;
  localparam int FLAG_BOD = 2;
  localparam int FLAG_WDT = 3;
  localparam int NUM_FILT = 2;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rstc_pulse_filter.sv
module rstc_pulse_filter #(
  parameter int MIN_CYC = 4
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic raw_i,
  output logic det_o
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] run_q;
  logic          det_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      run_q   <= '0;
      det_q   <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q) begin
        if (run_q < CW'(MIN_CYC)) run_q <= run_q + CW'(1);
        det_q <= (run_q >= CW'(MIN_CYC - 1));
      end else begin
        run_q <= '0;
        det_q <= 1'b0;
      end
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int DLY0 = 4,
  parameter int DLY1 = 8,
  parameter int DLY2 = 16,
  parameter int DLY3 = 32
) (
  input  logic       clk_i,
  input  logic       req_i,
  input  logic [1:0] sel_i,
  output logic       rst_o
);
  localparam int DMAX = rstc_pkg::max4(DLY0, DLY1, DLY2, DLY3);
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q;
  logic          done_q, hold1_q, hold2_q;

  always_comb begin
    case (sel_i)
      2'd0:    lim = CW'(DLY0);
      2'd1:    lim = CW'(DLY1);
      2'd2:    lim = CW'(DLY2);
      default: lim = CW'(DLY3);
    endcase
  end

  always_ff @(posedge clk_i or posedge req_i) begin
    if (req_i) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      hold1_q <= 1'b1;
      hold2_q <= 1'b1;
    end else begin
      if (cnt_q < lim) cnt_q <= cnt_q + CW'(1);
      done_q  <= done_q | (cnt_q >= lim);
      hold1_q <= ~done_q;
      hold2_q <= hold1_q;
    end
  end

  assign rst_o = hold2_q;
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_i,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] POR_ONLY = FLAG_W'(1) << FLAG_POR;

  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] keep;

  assign keep = wr_i ? wdata_i : '1;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) flags_q <= POR_ONLY;
    else       flags_q <= (flags_q & keep) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int MIN_PIN = 4,
  parameter int MIN_BOD = 6,
  parameter int DLY0    = 4,
  parameter int DLY1    = 8,
  parameter int DLY2    = 16,
  parameter int DLY3    = 32
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       ext_rst_n_i,
  input  logic       wdt_expire_i,
  input  logic       bod_det_i,
  input  logic       bod_en_i,
  input  logic [1:0] dly_sel_i,
  input  logic       flag_wr_i,
  input  logic [3:0] flag_wdata_i,
  output logic [3:0] flags_o,
  output logic       sys_rst_o
);
  logic [NUM_FILT-1:0] raw;
  logic [NUM_FILT-1:0] det;
  logic                src_req;
  logic [FLAG_W-1:0]   set_vec;

  assign raw[0] = ~ext_rst_n_i;
  assign raw[1] = bod_det_i & bod_en_i;

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    localparam int MINV = (i == 0) ? MIN_PIN : MIN_BOD;
    rstc_pulse_filter #(.MIN_CYC(MINV)) u_filt (
      .clk_i (clk_i),
      .clr_i (por_i),
      .raw_i (raw[i]),
      .det_o (det[i])
    );
  end

  assign src_req = por_i | (|det) | wdt_expire_i;

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_PIN] = det[0];
    set_vec[FLAG_BOD] = det[1];
    set_vec[FLAG_WDT] = wdt_expire_i;
  end

  rstc_stretch #(.DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)) u_stretch (
    .clk_i (clk_i),
    .req_i (src_req),
    .sel_i (dly_sel_i),
    .rst_o (sys_rst_o)
  );

  rstc_cause_reg u_cause (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .set_i   (set_vec),
    .wr_i    (flag_wr_i),
    .wdata_i (flag_wdata_i),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker (
  input logic       clk_i,
  input logic       por_i,
  input logic       wdt_expire_i,
  input logic       flag_wr_i,
  input logic [3:0] flags_o,
  input logic       sys_rst_o
);
  // R2: a watchdog pulse seen at an edge always finds reset asserted
  a_r2_wdt_forces_rst: assert property (@(posedge clk_i) disable iff (por_i)
    wdt_expire_i |-> sys_rst_o);

  // R3: release only after at least two quiet edges
  a_r3_release_after_quiet: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(sys_rst_o) |-> (!$past(wdt_expire_i) && !$past(wdt_expire_i, 2)));

  // R7: leaving power-on shows only the power-on flag, reset still held
  a_r7_por_flag_only: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_i) |-> (flags_o == 4'b0001 && sys_rst_o));

  // R8: a watchdog pulse sets its flag on the next edge
  a_r8_wdt_sets_flag: assert property (@(posedge clk_i) disable iff (por_i)
    wdt_expire_i |=> flags_o[3]);

  // R9: a flag can drop only after a write strobe
  a_r9_clear_needs_write: assert property (@(posedge clk_i) disable iff (por_i)
    (|($past(flags_o) & ~flags_o)) |-> $past(flag_wr_i));
endmodule

bind rstc_top rstc_checker u_chk (
  .clk_i        (clk_i),
  .por_i        (por_i),
  .wdt_expire_i (wdt_expire_i),
  .flag_wr_i    (flag_wr_i),
  .flags_o      (flags_o),
  .sys_rst_o    (sys_rst_o)
);

// File: tb/rstc_top_tb.sv
`timescale 1ns/1ps
module rstc_top_tb;
  localparam int MIN_PIN = 4;
  localparam int MIN_BOD = 6;
  localparam int D0 = 4, D1 = 8, D2 = 16, D3 = 32;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ext_n = 1'b1;
  logic       wdt = 1'b0;
  logic       bod = 1'b0;
  logic       bod_en = 1'b0;
  logic [1:0] tsel = 2'd0;
  logic       wr = 1'b0;
  logic [3:0] wdata = 4'd0;
  logic [3:0] flags;
  logic       sys_rst;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rstc_top #(.MIN_PIN(MIN_PIN), .MIN_BOD(MIN_BOD),
             .DLY0(D0), .DLY1(D1), .DLY2(D2), .DLY3(D3)) u_dut (
    .clk_i        (clk),
    .por_i        (por),
    .ext_rst_n_i  (ext_n),
    .wdt_expire_i (wdt),
    .bod_det_i    (bod),
    .bod_en_i     (bod_en),
    .dly_sel_i    (tsel),
    .flag_wr_i    (wr),
    .flag_wdata_i (wdata),
    .flags_o      (flags),
    .sys_rst_o    (sys_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dly_of(input logic [1:0] s);
    case (s)
      2'd0: return D0;
      2'd1: return D1;
      2'd2: return D2;
      default: return D3;
    endcase
  endfunction

  // behavioural reference model, compared every cycle
  int q_pin[$];
  int q_bod[$];
  int run_pin = 0, run_bod = 0;
  bit m_pin = 0, m_bod = 0;
  int quiet = 0;
  bit rel = 0;
  logic [3:0] m_flags = 4'b0001;
  bit src_old;
  bit exp_rst;

  always @(posedge clk) begin
    if (por) begin
      q_pin.delete(); q_bod.delete();
      run_pin = 0; run_bod = 0; m_pin = 0; m_bod = 0;
      quiet = 0; rel = 0; m_flags = 4'b0001;
    end else begin
      src_old = m_pin | m_bod | wdt;
      m_flags = (m_flags & (wr ? wdata : 4'hF)) | {wdt, m_bod, m_pin, 1'b0};
      if (src_old) begin quiet = 0; rel = 0; end
      else if (quiet < 100000) quiet++;
      if (quiet >= dly_of(tsel) + 3) rel = 1;
      q_pin.push_back(int'(!ext_n));
      if (q_pin.size() > 3) void'(q_pin.pop_front());
      if (q_pin.size() == 3) begin
        run_pin = (q_pin[0] != 0) ? run_pin + 1 : 0;
        m_pin = (run_pin >= MIN_PIN);
      end
      q_bod.push_back(int'(bod && bod_en));
      if (q_bod.size() > 3) void'(q_bod.pop_front());
      if (q_bod.size() == 3) begin
        run_bod = (q_bod[0] != 0) ? run_bod + 1 : 0;
        m_bod = (run_bod >= MIN_BOD);
      end
    end
    #1;
    exp_rst = por | m_pin | m_bod | wdt | !rel;
    chk("R3 R4 R5 R6 R10 sys_rst model", int'(sys_rst), int'(exp_rst));
    chk("R7 R8 R9 flags model", int'(flags), int'(m_flags));
  end

  task automatic wait_release(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (sys_rst && n < 1000);
  endtask

  task automatic pulse_wdt();
    @(negedge clk); wdt = 1'b1;
    #1 chk("R2 immediate on watchdog", int'(sys_rst), 1);
    @(negedge clk); wdt = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset held by power-on", int'(sys_rst), 1);
    chk("R7 power-on flags", int'(flags), 4'b0001);
    @(negedge clk); por = 1'b0;
    wait_release(n);
    chk("R3 delay sel0", n, D0 + 3);

    tsel = 2'd2;
    pulse_wdt();
    wait_release(n);
    chk("R3 delay sel2", n, D2 + 3);
    chk("R8 watchdog flag", int'(flags), 4'b1001);

    // R9: write zero clears, write one keeps
    @(negedge clk); wr = 1'b1; wdata = 4'b1110;
    @(negedge clk); wr = 1'b0;
    #1 chk("R9 clear by zero", int'(flags), 4'b1000);
    @(negedge clk); wr = 1'b1; wdata = 4'b1111;
    @(negedge clk); wr = 1'b0;
    #1 chk("R9 one has no effect", int'(flags), 4'b1000);

    // R4: short pin pulse filtered
    tsel = 2'd0;
    @(negedge clk); ext_n = 1'b0;
    repeat (MIN_PIN - 1) @(negedge clk);
    ext_n = 1'b1;
    repeat (8) @(negedge clk);
    #1 chk("R4 short pin ignored rst", int'(sys_rst), 0);
    chk("R4 short pin ignored flags", int'(flags), 4'b1000);

    // R4: long pin pulse recognised
    @(negedge clk); ext_n = 1'b0;
    repeat (MIN_PIN + 3) @(negedge clk);
    #1 chk("R4 long pin resets", int'(sys_rst), 1);
    @(negedge clk); ext_n = 1'b1;
    wait_release(n);
    chk("R4 R8 pin flag", int'(flags), 4'b1010);

    // R6: brown-out ignored while disabled
    @(negedge clk); bod = 1'b1; bod_en = 1'b0;
    repeat (20) @(negedge clk);
    #1 chk("R6 disabled brown-out rst", int'(sys_rst), 0);
    chk("R6 disabled brown-out flags", int'(flags), 4'b1010);
    @(negedge clk); bod = 1'b0; bod_en = 1'b1;

    // R5: short brown-out filtered, long recognised
    @(negedge clk); bod = 1'b1;
    repeat (MIN_BOD - 1) @(negedge clk);
    bod = 1'b0;
    repeat (8) @(negedge clk);
    #1 chk("R5 short brown-out ignored", int'(sys_rst), 0);
    @(negedge clk); bod = 1'b1;
    repeat (MIN_BOD + 2) @(negedge clk);
    #1 chk("R5 long brown-out resets", int'(sys_rst), 1);
    @(negedge clk); bod = 1'b0;
    wait_release(n);
    chk("R5 R8 brown-out flag", int'(flags), 4'b1110);

    // R9: set wins over clear on the same edge
    @(negedge clk); wdt = 1'b1; wr = 1'b1; wdata = 4'b0000;
    @(negedge clk); wdt = 1'b0; wr = 1'b0;
    #1 chk("R9 set beats clear", int'(flags), 4'b1000);
    wait_release(n);

    // R10: retrigger restarts the delay
    tsel = 2'd1;
    pulse_wdt();
    repeat (5) @(posedge clk);
    #1 chk("R10 still held mid-delay", int'(sys_rst), 1);
    pulse_wdt();
    wait_release(n);
    chk("R10 delay restarted", n, D1 + 3);

    // R1 R7: power-on again
    @(negedge clk); por = 1'b1;
    #1 chk("R1 immediate on power-on", int'(sys_rst), 1);
    chk("R7 flags forced by power-on", int'(flags), 4'b0001);
    @(negedge clk); por = 1'b0;
    wait_release(n);
    chk("R3 delay sel1 after power-on", n, D1 + 3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule